// File: doc/BRIEF.md
# ULPI RXCMD Status Generator

This block sits on the PHY side of a ULPI link and reports bus status to the link controller. It samples the USB line state, the receive event code, three VBUS comparator outputs and an optional external fault input. When a reportable change occurs, it claims the data bus by raising the direction output and sends one status byte, called an RXCMD, to the link.

Line-state and receive-event changes are always reported. Comparator edges are reported only when software has enabled that edge through a per-comparator rising mask or falling mask. A separate pair of enables selects session-valid edges for the alternate interrupt flag in bit 7. Changes that arrive while a byte is already in progress are merged, so the next byte always carries the newest state. While the PHY is in low-power mode, nothing is reported.

Top module: `ulpi_rxcmd_gen`

## Requirements
- R1: The status byte is laid out as line state in bits 1:0, VBUS code in bits 3:2, receive event in bits 5:4, bit 6 always 0 and the alternate interrupt flag in bit 7. The data output is 0 in every cycle in which no byte is valid.
- R2: After reset, `dir` is low and no byte is valid. After a triggering change, `dir` rises on the next clock edge with no byte valid (turnaround). The byte is valid on the following edge. `dir` stays high for one cycle after the last byte and then falls.
- R3: Any change of `line_state` or `rx_event` produces exactly one byte, whatever the masks are set to.
- R4: The VBUS code is 2'b11 when the A-valid source is high. Otherwise it is 2'b10 when session-valid (`cmp_in[1]`) is high. Otherwise it is 2'b01 when session-end (`cmp_in[0]`) is low, and 2'b00 in the remaining case. The A-valid source is `cmp_in[2]`.
- R5: A rising edge of `cmp_in[i]` produces a byte only if `rise_en[i]` is set. A falling edge produces a byte only if `fall_en[i]` is set. Bit 0 is session-end, bit 1 is session-valid and bit 2 is VBUS-valid.
- R6: When `fault_sel` is 1, the A-valid source is `cmp_in[2] & ~fault_in`, and any change of `fault_in` produces a byte regardless of the masks. When `fault_sel` is 0, `fault_in` has no effect.
- R7: A rising edge of session-valid with `alt_rise_en` set, or a falling edge with `alt_fall_en` set, produces a byte with bit 7 set to 1, even when every mask is clear. Bytes caused by anything else carry bit 7 = 0.
- R8: A change that arrives while a byte is being driven produces a second byte on the very next cycle, and `dir` stays high between the two bytes.
- R9: Changes that arrive after the bus request but before the byte is loaded are merged into a single byte that holds the newest state.
- R10: While `low_power` is 1, no byte is sent and an idle `dir` stays low. Changes that occur during low power are discarded and are not reported after `low_power` returns to 0.
- R11: `reg_abort` pulses for one cycle, in the same cycle that `dir` rises, if `reg_busy` is high when the bus request is made. It stays 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_state | input | 2 | Current USB line state |
| rx_event | input | 2 | Encoded receive event |
| cmp_in | input | 3 | Comparators: [0] session-end, [1] session-valid, [2] VBUS-valid |
| fault_in | input | 1 | External VBUS fault, active high |
| fault_sel | input | 1 | Use the fault input to qualify A-valid |
| rise_en | input | 3 | Per-comparator rising-edge report enable |
| fall_en | input | 3 | Per-comparator falling-edge report enable |
| alt_rise_en | input | 1 | Session-valid rise sets the alternate flag |
| alt_fall_en | input | 1 | Session-valid fall sets the alternate flag |
| low_power | input | 1 | PHY is in low-power mode |
| reg_busy | input | 1 | Link has a register operation in progress |
| dir | output | 1 | Bus direction, high while the PHY owns the bus |
| rxcmd_valid | output | 1 | A status byte is on `rxcmd_data` |
| rxcmd_data | output | 8 | Status byte |
| reg_abort | output | 1 | Register operation aborted by a bus request |

## Verification
Two functions can fall in the same cycle: the sequencer loading a byte, and a new status change arriving. The bench provokes this in two ways. It changes the line state in the cycle a byte is on the bus, and it changes the line state in the turnaround cycle before the load. The scoreboard then judges whether the first case gives two consecutive bytes and the second gives exactly one byte with the newer state. Masked comparator edges, fault changes while the fault source is deselected, and low-power changes are judged by the absence of any byte at the ports.

// File: rtl/rxcmd_pkg.sv
`timescale 1ns/1ps
package rxcmd_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE    = 2'd0,
      SQ_TURN_UP = 2'd1,
      SQ_SEND    = 2'd2,
      SQ_TURN_DN = 2'd3
   } seq_state_t;

   // Thermometer-style VBUS level code
   function automatic logic [1:0] vbus_encode(input logic a_vld,
                                              input logic s_vld,
                                              input logic s_end);
      if (a_vld)       return 2'b11;
      else if (s_vld)  return 2'b10;
      else if (!s_end) return 2'b01;
      else             return 2'b00;
   endfunction
endpackage

// File: rtl/rxcmd_edge_mask.sv
`timescale 1ns/1ps
module rxcmd_edge_mask #(
   parameter int NCMP      = 3,
   parameter int LS_W      = 2,
   parameter int EV_W      = 2,
   parameter int BV_IDX    = 1,
   parameter bit HAS_FAULT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LS_W-1:0] ls,
   input  logic [EV_W-1:0] ev,
   input  logic [NCMP-1:0] cmp,
   input  logic [NCMP-1:0] rise_en,
   input  logic [NCMP-1:0] fall_en,
   input  logic            alt_rise_en,
   input  logic            alt_fall_en,
   input  logic            fault,
   input  logic            fault_sel,
   output logic            trig,
   output logic            alt_trig
);
   logic [LS_W-1:0] ls_q;
   logic [EV_W-1:0] ev_q;
   logic [NCMP-1:0] cmp_q;
   logic [NCMP-1:0] hit;
   logic            fault_hit;

   // previous-value registers load the live inputs in reset: no spurious edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ls_q  <= ls;
         ev_q  <= ev;
         cmp_q <= cmp;
      end else begin
         ls_q  <= ls;
         ev_q  <= ev;
         cmp_q <= cmp;
      end
   end

   for (genvar g = 0; g < NCMP; g++) begin : g_cmp
      assign hit[g] = (cmp[g] & ~cmp_q[g] & rise_en[g]) |
                      (~cmp[g] & cmp_q[g] & fall_en[g]);
   end

   if (HAS_FAULT) begin : g_fault
      logic fault_q;
      always_ff @(posedge clk) begin
         fault_q <= fault;
      end
      assign fault_hit = fault_sel & (fault ^ fault_q) & rst_n;
   end else begin : g_nofault
      assign fault_hit = 1'b0;
   end

   assign alt_trig = (cmp[BV_IDX] & ~cmp_q[BV_IDX] & alt_rise_en) |
                     (~cmp[BV_IDX] & cmp_q[BV_IDX] & alt_fall_en);

   assign trig = (ls != ls_q) | (ev != ev_q) | (|hit) | fault_hit | alt_trig;
endmodule

// File: rtl/rxcmd_stat_fmt.sv
`timescale 1ns/1ps
module rxcmd_stat_fmt
   import rxcmd_pkg::*;
#(
   parameter int NCMP      = 3,
   parameter int LS_W      = 2,
   parameter int EV_W      = 2,
   parameter bit HAS_FAULT = 1'b1,
   localparam int STAT_W   = LS_W + 2 + EV_W + 1
) (
   input  logic [LS_W-1:0]   ls,
   input  logic [EV_W-1:0]   ev,
   input  logic [NCMP-1:0]   cmp,
   input  logic              fault,
   input  logic              fault_sel,
   output logic [STAT_W-1:0] stat
);
   logic a_vld;

   if (HAS_FAULT) begin : g_fq
      assign a_vld = fault_sel ? (cmp[2] & ~fault) : cmp[2];
   end else begin : g_nfq
      assign a_vld = cmp[2];
   end

   assign stat = {1'b0, ev, vbus_encode(a_vld, cmp[1], cmp[0]), ls};
endmodule

// File: rtl/rxcmd_seq.sv
`timescale 1ns/1ps
module rxcmd_seq
   import rxcmd_pkg::*;
#(
   parameter int BYTE_W  = 8,
   localparam int STAT_W = BYTE_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic              alt_trig,
   input  logic [STAT_W-1:0] stat,
   input  logic              low_power,
   input  logic              reg_busy,
   output logic              dir,
   output logic              valid,
   output logic [BYTE_W-1:0] data,
   output logic              reg_abort
);
   seq_state_t state_q, state_d;
   logic       pend_q, alt_q;
   logic       want, load;

   assign want = (pend_q | trig) & ~low_power;
   assign load = want & ((state_q == SQ_TURN_UP) | (state_q == SQ_SEND));

   always_comb begin
      state_d = state_q;
      case (state_q)
         SQ_IDLE:    if (want) state_d = SQ_TURN_UP;
         SQ_TURN_UP: state_d = want ? SQ_SEND : SQ_TURN_DN;
         SQ_SEND:    state_d = want ? SQ_SEND : SQ_TURN_DN;
         SQ_TURN_DN: state_d = SQ_IDLE;
         default:    state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         pend_q    <= 1'b0;
         alt_q     <= 1'b0;
         data      <= '0;
         valid     <= 1'b0;
         reg_abort <= 1'b0;
      end else begin
         state_q   <= state_d;
         reg_abort <= (state_q == SQ_IDLE) & want & reg_busy;
         if (low_power || load) begin
            pend_q <= 1'b0;
            alt_q  <= 1'b0;
         end else begin
            pend_q <= pend_q | trig;
            alt_q  <= alt_q | alt_trig;
         end
         if (load) begin
            data  <= {alt_q | alt_trig, stat};
            valid <= 1'b1;
         end else begin
            data  <= '0;
            valid <= 1'b0;
         end
      end
   end

   assign dir = (state_q != SQ_IDLE);
endmodule

// File: rtl/ulpi_rxcmd_gen.sv
`timescale 1ns/1ps
module ulpi_rxcmd_gen #(
   parameter int NCMP      = 3,
   parameter int LS_W      = 2,
   parameter int EV_W      = 2,
   parameter int BV_IDX    = 1,
   parameter bit HAS_FAULT = 1'b1,
   localparam int VB_W     = 2,
   localparam int BYTE_W   = LS_W + VB_W + EV_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LS_W-1:0]   line_state,
   input  logic [EV_W-1:0]   rx_event,
   input  logic [NCMP-1:0]   cmp_in,
   input  logic              fault_in,
   input  logic              fault_sel,
   input  logic [NCMP-1:0]   rise_en,
   input  logic [NCMP-1:0]   fall_en,
   input  logic              alt_rise_en,
   input  logic              alt_fall_en,
   input  logic              low_power,
   input  logic              reg_busy,
   output logic              dir,
   output logic              rxcmd_valid,
   output logic [BYTE_W-1:0] rxcmd_data,
   output logic              reg_abort
);
   if (BYTE_W != 8) begin : g_bad_width
      $error("status byte must total 8 bits");
   end
   if (NCMP != 3) begin : g_bad_ncmp
      $error("exactly three comparators are encoded");
   end
   if (BV_IDX >= NCMP) begin : g_bad_bv
      $error("session-valid index out of range");
   end

   logic              trig, alt_trig;
   logic [BYTE_W-2:0] stat;

   rxcmd_edge_mask #(
      .NCMP(NCMP), .LS_W(LS_W), .EV_W(EV_W),
      .BV_IDX(BV_IDX), .HAS_FAULT(HAS_FAULT)
   ) u_edge (
      .clk(clk), .rst_n(rst_n),
      .ls(line_state), .ev(rx_event), .cmp(cmp_in),
      .rise_en(rise_en), .fall_en(fall_en),
      .alt_rise_en(alt_rise_en), .alt_fall_en(alt_fall_en),
      .fault(fault_in), .fault_sel(fault_sel),
      .trig(trig), .alt_trig(alt_trig)
   );

   rxcmd_stat_fmt #(
      .NCMP(NCMP), .LS_W(LS_W), .EV_W(EV_W), .HAS_FAULT(HAS_FAULT)
   ) u_fmt (
      .ls(line_state), .ev(rx_event), .cmp(cmp_in),
      .fault(fault_in), .fault_sel(fault_sel), .stat(stat)
   );

   rxcmd_seq #(.BYTE_W(BYTE_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .trig(trig), .alt_trig(alt_trig), .stat(stat),
      .low_power(low_power), .reg_busy(reg_busy),
      .dir(dir), .valid(rxcmd_valid), .data(rxcmd_data),
      .reg_abort(reg_abort)
   );
endmodule

// File: rtl/ulpi_rxcmd_gen_chk.sv
`timescale 1ns/1ps
module ulpi_rxcmd_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       low_power,
   input logic       dir,
   input logic       rxcmd_valid,
   input logic [7:0] rxcmd_data,
   input logic       reg_abort
);
   // R2
   valid_has_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rxcmd_valid |-> dir);
   // R2
   turn_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dir) |-> !rxcmd_valid);
   // R2
   turn_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dir) |-> !$past(rxcmd_valid));
   // R1
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rxcmd_valid |-> !rxcmd_data[6]);
   // R1
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rxcmd_valid |-> (rxcmd_data == 8'h00));
   // R10
   lp_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power && !dir) |=> !dir);
   // R11
   abort_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_abort |-> $rose(dir));
endmodule

bind ulpi_rxcmd_gen ulpi_rxcmd_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .low_power(low_power), .dir(dir),
   .rxcmd_valid(rxcmd_valid), .rxcmd_data(rxcmd_data), .reg_abort(reg_abort)
);

// File: tb/ulpi_rxcmd_gen_bench.sv
`timescale 1ns/1ps
module ulpi_rxcmd_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] line_state = 2'b01;
   logic [1:0] rx_event = 2'b00;
   logic [2:0] cmp_in = 3'b000;
   logic       fault_in = 1'b0, fault_sel = 1'b0;
   logic [2:0] rise_en = 3'b000, fall_en = 3'b000;
   logic       alt_rise_en = 1'b0, alt_fall_en = 1'b0;
   logic       low_power = 1'b0, reg_busy = 1'b0;
   logic       dir, rxcmd_valid, reg_abort;
   logic [7:0] rxcmd_data;

   int  n_chk = 0, n_fail = 0, n_seen = 0;
   bit  done = 1'b0;
   logic [7:0] exp_q[$];
   string      req_q[$];

   always #2.5 clk = ~clk;

   ulpi_rxcmd_gen u_ulpi_rxcmd_gen (
      .clk(clk), .rst_n(rst_n), .line_state(line_state), .rx_event(rx_event),
      .cmp_in(cmp_in), .fault_in(fault_in), .fault_sel(fault_sel),
      .rise_en(rise_en), .fall_en(fall_en),
      .alt_rise_en(alt_rise_en), .alt_fall_en(alt_fall_en),
      .low_power(low_power), .reg_busy(reg_busy),
      .dir(dir), .rxcmd_valid(rxcmd_valid), .rxcmd_data(rxcmd_data),
      .reg_abort(reg_abort)
   );

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   // expected byte from the requirements (R1, R4, R6)
   function automatic logic [7:0] exp_byte(input logic alt);
      logic       av;
      logic [1:0] vb;
      av = fault_sel ? (cmp_in[2] & ~fault_in) : cmp_in[2];
      vb = av ? 2'b11 : cmp_in[1] ? 2'b10 : !cmp_in[0] ? 2'b01 : 2'b00;
      return {alt, 1'b0, rx_event, vb, line_state};
   endfunction

   task automatic push(input string r, input logic alt);
      exp_q.push_back(exp_byte(alt));
      req_q.push_back(r);
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rxcmd_valid) begin
         n_seen++;
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL unexpected byte actual=%0h expected=none", rxcmd_data);
         end else begin
            logic [7:0] e;
            string      r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(r, {24'd0, rxcmd_data}, {24'd0, e});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         report();
      end
   end

   initial begin
      int seen0;
      repeat (3) @(negedge clk);
      chk("R2 reset dir", {31'd0, dir}, 0);
      chk("R2 reset valid", {31'd0, rxcmd_valid}, 0);
      chk("R1 reset data", {24'd0, rxcmd_data}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 idle dir", {31'd0, dir}, 0);

      // R3 line state change, with R2 turnaround timing
      line_state = 2'b10; push("R3 line state", 1'b0);
      @(negedge clk);
      chk("R2 turnaround dir", {31'd0, dir}, 1);
      chk("R2 turnaround no byte", {31'd0, rxcmd_valid}, 0);
      @(negedge clk);
      chk("R2 byte valid", {31'd0, rxcmd_valid}, 1);
      @(negedge clk);
      chk("R2 hold dir", {31'd0, dir}, 1);
      chk("R2 hold no byte", {31'd0, rxcmd_valid}, 0);
      @(negedge clk);
      chk("R2 release dir", {31'd0, dir}, 0);
      settle();

      // R3 receive event
      rx_event = 2'b01; push("R3 rx event", 1'b0); settle();

      // R5 masked comparator edges
      seen0 = n_seen;
      cmp_in[0] = 1'b1; settle();
      cmp_in[0] = 1'b0; settle();
      chk("R5 masked edges", n_seen, seen0);
      rise_en = 3'b001; @(negedge clk);
      cmp_in[0] = 1'b1; push("R5 session-end rise", 1'b0); settle();

      // R4 code levels
      rise_en = 3'b111; @(negedge clk);
      cmp_in[1] = 1'b1; push("R4 code 10", 1'b0); settle();
      cmp_in[2] = 1'b1; push("R4 code 11", 1'b0); settle();
      fall_en = 3'b100; @(negedge clk);
      cmp_in[2] = 1'b0; push("R4 vbus fall", 1'b0); settle();

      // R7 alternate flag
      alt_fall_en = 1'b1; @(negedge clk);
      cmp_in[1] = 1'b0; push("R7 alt fall", 1'b1); settle();
      alt_rise_en = 1'b1; @(negedge clk);
      cmp_in[1] = 1'b1; push("R7 alt rise", 1'b1); settle();
      alt_rise_en = 1'b0; alt_fall_en = 1'b0; fall_en = 3'b010; @(negedge clk);
      cmp_in[1] = 1'b0; push("R7 plain fall", 1'b0); settle();
      rise_en = 3'b000; fall_en = 3'b000; alt_rise_en = 1'b1; @(negedge clk);
      cmp_in[1] = 1'b1; push("R7 alt alone", 1'b1); settle();
      alt_rise_en = 1'b0;

      // R6 fault source
      rise_en = 3'b100; @(negedge clk);
      cmp_in[2] = 1'b1; push("R4 vbus rise", 1'b0); settle();
      rise_en = 3'b000; fault_sel = 1'b1; @(negedge clk);
      fault_in = 1'b1; push("R6 fault set", 1'b0); settle();
      fault_in = 1'b0; push("R6 fault clear", 1'b0); settle();
      fault_sel = 1'b0; @(negedge clk);
      seen0 = n_seen;
      fault_in = 1'b1; settle();
      fault_in = 1'b0; settle();
      chk("R6 fault ignored", n_seen, seen0);

      // R8 back-to-back
      line_state = 2'b00; push("R8 first", 1'b0);
      @(negedge clk);
      @(negedge clk);
      chk("R8 first valid", {31'd0, rxcmd_valid}, 1);
      line_state = 2'b11; push("R8 second", 1'b0);
      @(negedge clk);
      chk("R8 second valid", {31'd0, rxcmd_valid}, 1);
      chk("R8 dir held", {31'd0, dir}, 1);
      settle();

      // R9 merge before load
      seen0 = n_seen;
      line_state = 2'b01;
      @(negedge clk);
      line_state = 2'b10; push("R9 merged", 1'b0);
      settle();
      chk("R9 one byte", n_seen, seen0 + 1);

      // R10 low power
      low_power = 1'b1; @(negedge clk);
      seen0 = n_seen;
      line_state = 2'b01;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R10 dir low", {31'd0, dir}, 0);
      end
      rx_event = 2'b10; settle();
      low_power = 1'b0; settle();
      chk("R10 discarded", n_seen, seen0);
      line_state = 2'b10; push("R10 after wake", 1'b0); settle();

      // R11 abort
      reg_busy = 1'b1; @(negedge clk);
      line_state = 2'b01; push("R11 busy", 1'b0);
      @(negedge clk);
      chk("R11 abort pulse", {31'd0, reg_abort}, 1);
      @(negedge clk);
      chk("R11 abort one cycle", {31'd0, reg_abort}, 0);
      settle();
      reg_busy = 1'b0; @(negedge clk);
      line_state = 2'b10; push("R11 idle", 1'b0);
      @(negedge clk);
      chk("R11 no abort", {31'd0, reg_abort}, 0);
      settle();

      chk("R3 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      report();
   end
endmodule